// File: doc/BRIEF.md
# Windowed Keyed Deadman Timer

A supervisory counter that software must service before it runs out. Once enabled, the count advances by one every clock. Software restarts it with two keyed writes: an arm key to one register, then a confirm key to another. The confirm key is only honoured once the count has entered a service window near the end of the period. A wrong key, a confirm with no arm, or a confirm outside the window sets its own status flag and leaves the count running.

If the count reaches the end of the period without a good restart, the block raises a timeout flag and pulses a reset request for one cycle. It also sets a sticky reset-cause bit that software clears explicitly. The timeout in seconds is the period register value divided by the timer clock rate.

Stopping the timer opens a one-cycle quiet slot right after the stop write. In that slot, register accesses are dropped.

Top module: `keyed_deadman_timer`

## Requirements
- R1: After reset, control (0x00), status (0x30), count (0x40) and reset cause (0x80) read 0, period (0x60) reads PERIOD_RST, window (0x70) reads WIN_RST, and rst_req_o and rst_cause_o are low.
- R2: While control bit 15 is 1 and the period is nonzero, the count starts from 0 and rises by one every clock.
- R3: Status bit 0 reads 1 exactly while the timer runs and count >= period - window. The threshold floors at 0 when the window is not smaller than the period.
- R4: An arm write of 0x4000 to 0x10 (key 0x40 in bits 15:8), then a write to 0x20 with 0x08 in bits 7:0 while the window is open, returns the count to 0, closes the window and sets no flag.
- R5: A write to 0x10 whose bits 15:8 are not 0x40 sets status bit 7 and discards any pending arm.
- R6: A write to 0x20 sets status bit 6 and leaves the count running in three cases: no arm is pending, the window is closed, or bits 7:0 are not 0x08.
- R7: A timeout occurs when a clock edge finds the count at period - 1 with no good confirm. The count wraps to 0, status bit 5 sets, and rst_req_o is high for exactly the one following cycle.
- R8: A timeout sets bit 5 of the reset-cause register and rst_cause_o. Both stay set until a write to 0x80 with bit 5 = 1.
- R9: Writing 1 to status bits 7, 6 or 5 clears that flag. Writing 0 leaves it unchanged.
- R10: With period 0, the timer holds the count at 0 and never times out.
- R11: Clearing control bit 15 returns the count to 0. In the cycle after that write, reads return 0 and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Register byte offset |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational from addr_i |
| rst_req_o | output | 1 | One-cycle reset request on timeout |
| rst_cause_o | output | 1 | Sticky timeout reset cause |

## Verification
The restart sequence is tried in four forms:
- a correct arm and confirm inside the window, which must zero the count;
- the correct pair issued early, which tells a window check apart from a pure key check;
- a confirm with no arm, inside the window, which shows the arm is really tracked;
- a wrong arm key followed by a correct confirm, which shows a bad arm cancels the pending state rather than just flagging it.

The count is read back at exact cycle offsets at the window edge and at expiry, so an off-by-one in the threshold or the wrap is exposed. Period zero and the quiet slot after a stop are driven separately.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_ARM    = 8'h10;
  localparam logic [7:0] OFF_CONF   = 8'h20;
  localparam logic [7:0] OFF_STAT   = 8'h30;
  localparam logic [7:0] OFF_CNT    = 8'h40;
  localparam logic [7:0] OFF_PER    = 8'h60;
  localparam logic [7:0] OFF_WIN    = 8'h70;
  localparam logic [7:0] OFF_RCAUSE = 8'h80;

  localparam logic [7:0] ARM_KEY  = 8'h40;
  localparam logic [7:0] CONF_KEY = 8'h08;

  localparam int EN_BIT   = 15;
  localparam int WIN_BIT  = 0;
  localparam int EVT_BIT  = 5;
  localparam int BAD2_BIT = 6;
  localparam int BAD1_BIT = 7;
  localparam int RC_BIT   = 5;

  typedef struct packed {
    logic bad1;
    logic bad2;
    logic evt;
  } flags_t;
endpackage

// File: rtl/dmt_regs.sv
module dmt_regs
  import dmt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 32,
  parameter logic [CW-1:0] PERIOD_RST = 1024,
  parameter logic [CW-1:0] WIN_RST    = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          expire_i,
  output logic          en_o,
  output logic [CW-1:0] period_o,
  output logic [CW-1:0] window_o,
  output logic          rcause_o,
  output logic          guard_o,
  output logic          rc_clr_o
);
  logic ctrl_wr, per_wr, win_wr;
  logic en_q, rc_q, guard_q;
  logic [CW-1:0] per_q, win_q;

  assign ctrl_wr  = wr_i && (addr_i == AW'(OFF_CTRL));
  assign per_wr   = wr_i && (addr_i == AW'(OFF_PER));
  assign win_wr   = wr_i && (addr_i == AW'(OFF_WIN));
  assign rc_clr_o = wr_i && (addr_i == AW'(OFF_RCAUSE)) && wdata_i[RC_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      per_q   <= PERIOD_RST;
      win_q   <= WIN_RST;
      rc_q    <= 1'b0;
      guard_q <= 1'b0;
    end else begin
      // quiet slot follows a stop write
      guard_q <= ctrl_wr && !wdata_i[EN_BIT] && en_q;
      if (ctrl_wr) en_q <= wdata_i[EN_BIT];
      if (per_wr)  per_q <= wdata_i[CW-1:0];
      if (win_wr)  win_q <= wdata_i[CW-1:0];
      if (expire_i)      rc_q <= 1'b1;
      else if (rc_clr_o) rc_q <= 1'b0;
    end
  end

  assign en_o     = en_q;
  assign period_o = per_q;
  assign window_o = win_q;
  assign rcause_o = rc_q;
  assign guard_o  = guard_q;
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] window_i,
  input  logic          clr_i,
  output logic [CW-1:0] count_o,
  output logic          win_open_o,
  output logic          expire_o
);
  logic [CW-1:0] count_q, thresh;
  logic run, last;

  assign run      = en_i && (period_i != '0);
  assign thresh   = (window_i >= period_i) ? '0 : period_i - window_i;
  // >= also catches a period shrunk below the running count
  assign last     = count_q >= (period_i - CW'(1));
  assign win_open_o = run && (count_q >= thresh);
  assign expire_o   = run && last && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            count_q <= '0;
    else if (!run)          count_q <= '0;
    else if (clr_i || last) count_q <= '0;
    else                    count_q <= count_q + CW'(1);
  end

  assign count_o = count_q;
endmodule

// File: rtl/dmt_keyseq.sv
module dmt_keyseq
  import dmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       arm_wr_i,
  input  logic [7:0] arm_key_i,
  input  logic       conf_wr_i,
  input  logic [7:0] conf_key_i,
  input  logic       win_open_i,
  input  logic       expire_i,
  input  flags_t     w1c_i,
  output logic       clr_ok_o,
  output logic       pending_o,
  output flags_t     flags_o
);
  logic   pend_q;
  flags_t flg_q, set;

  assign clr_ok_o = conf_wr_i && pend_q && win_open_i && (conf_key_i == CONF_KEY);
  assign set.bad1 = arm_wr_i && (arm_key_i != ARM_KEY);
  assign set.bad2 = conf_wr_i && !clr_ok_o;
  assign set.evt  = expire_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      flg_q  <= '0;
    end else begin
      if (!en_i || conf_wr_i || expire_i) pend_q <= 1'b0;
      else if (arm_wr_i)                  pend_q <= (arm_key_i == ARM_KEY);
      // a new event outranks a simultaneous clear
      flg_q <= set | (flg_q & ~w1c_i);
    end
  end

  assign pending_o = pend_q;
  assign flags_o   = flg_q;
endmodule

// File: rtl/keyed_deadman_timer.sv
module keyed_deadman_timer
  import dmt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 32,
  parameter logic [CW-1:0] PERIOD_RST = 1024,
  parameter logic [CW-1:0] WIN_RST    = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rst_req_o,
  output logic          rst_cause_o
);
  logic guard, wr_ok, rd_ok;
  logic en, rcause, rc_clr;
  logic [CW-1:0] period, window, cnt;
  logic win_open, expire, clr_ok, pending;
  logic arm_wr, conf_wr, stat_wr;
  flags_t flags, stat_w1c;
  logic rst_req_q;

  assign wr_ok   = wr_en_i & ~guard;
  assign rd_ok   = rd_en_i & ~guard;
  assign arm_wr  = wr_ok && (addr_i == AW'(OFF_ARM));
  assign conf_wr = wr_ok && (addr_i == AW'(OFF_CONF));
  assign stat_wr = wr_ok && (addr_i == AW'(OFF_STAT));
  assign stat_w1c = stat_wr ? flags_t'({wdata_i[BAD1_BIT], wdata_i[BAD2_BIT], wdata_i[EVT_BIT]})
                            : '0;

  dmt_regs #(
    .AW(AW), .DW(DW), .CW(CW), .PERIOD_RST(PERIOD_RST), .WIN_RST(WIN_RST)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_ok),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .expire_i (expire),
    .en_o     (en),
    .period_o (period),
    .window_o (window),
    .rcause_o (rcause),
    .guard_o  (guard),
    .rc_clr_o (rc_clr)
  );

  dmt_counter #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .period_i   (period),
    .window_i   (window),
    .clr_i      (clr_ok),
    .count_o    (cnt),
    .win_open_o (win_open),
    .expire_o   (expire)
  );

  dmt_keyseq u_keys (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .arm_wr_i   (arm_wr),
    .arm_key_i  (wdata_i[15:8]),
    .conf_wr_i  (conf_wr),
    .conf_key_i (wdata_i[7:0]),
    .win_open_i (win_open),
    .expire_i   (expire),
    .w1c_i      (stat_w1c),
    .clr_ok_o   (clr_ok),
    .pending_o  (pending),
    .flags_o    (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= expire;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      case (addr_i)
        AW'(OFF_CTRL):   rdata_o[EN_BIT] = en;
        AW'(OFF_ARM):    if (pending) rdata_o[15:8] = ARM_KEY;
        AW'(OFF_STAT): begin
          rdata_o[WIN_BIT]  = win_open;
          rdata_o[EVT_BIT]  = flags.evt;
          rdata_o[BAD2_BIT] = flags.bad2;
          rdata_o[BAD1_BIT] = flags.bad1;
        end
        AW'(OFF_CNT):    rdata_o = DW'(cnt);
        AW'(OFF_PER):    rdata_o = DW'(period);
        AW'(OFF_WIN):    rdata_o = DW'(window);
        AW'(OFF_RCAUSE): rdata_o[RC_BIT] = rcause;
        default:         rdata_o = '0;
      endcase
    end
  end

  assign rst_req_o   = rst_req_q;
  assign rst_cause_o = rcause;
endmodule

// File: rtl/keyed_deadman_timer_chk.sv
module keyed_deadman_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rst_req_i,
  input logic          rst_cause_i,
  input logic          en_i,
  input logic [CW-1:0] cnt_i,
  input logic          clr_ok_i,
  input logic          guard_i,
  input logic [CW-1:0] period_i,
  input logic          rc_clr_i,
  input logic          expire_i
);
  // R7
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !rst_req_i);

  // R8
  cause_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> rst_cause_i);

  // R8
  cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_cause_i && !rc_clr_i) |=> rst_cause_i);

  // R4
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ok_i |=> (cnt_i == '0));

  // R11
  off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0));

  // R11
  guard_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guard_i |=> $stable(period_i));

  // R10
  zero_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |-> !expire_i);
endmodule

bind keyed_deadman_timer keyed_deadman_timer_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_req_i   (rst_req_o),
  .rst_cause_i (rst_cause_o),
  .en_i        (en),
  .cnt_i       (cnt),
  .clr_ok_i    (clr_ok),
  .guard_i     (guard),
  .period_i    (period),
  .rc_clr_i    (rc_clr),
  .expire_i    (expire)
);

// File: tb/keyed_deadman_timer_tb.sv
`timescale 1ns/1ps
module keyed_deadman_timer_tb;
  localparam int AW = 8;
  localparam int DW = 32;

  localparam logic [7:0] A_CTRL = 8'h00, A_ARM = 8'h10, A_CONF = 8'h20, A_STAT = 8'h30;
  localparam logic [7:0] A_CNT = 8'h40, A_PER = 8'h60, A_WIN = 8'h70, A_RC = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rst_req, rst_cause;

  int n_run = 0;
  int n_fail = 0;
  int req_seen = 0;

  always #2.5 clk = ~clk;

  keyed_deadman_timer #(.AW(AW), .DW(DW), .CW(32), .PERIOD_RST(1024), .WIN_RST(256)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .rd_en_i     (rd_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .rst_req_o   (rst_req),
    .rst_cause_o (rst_cause)
  );

  always @(negedge clk) if (rst_req) req_seen++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1;
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_timer();
    wr(A_CTRL, 32'h0);
    step(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); check("R1 status", v, 32'h0);
    rd(A_CNT, v);  check("R1 count", v, 32'h0);
    rd(A_PER, v);  check("R1 period", v, 32'd1024);
    rd(A_WIN, v);  check("R1 window", v, 32'd256);
    rd(A_RC, v);   check("R1 cause", v, 32'h0);
    check("R1 rst_req", rst_req, 1'b0);
    check("R1 rst_cause", rst_cause, 1'b0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(A_PER, 32'd40);
    wr(A_WIN, 32'd10);
    wr(A_CTRL, 32'h8000);
    rd(A_CNT, v); check("R2 count start", v, 32'd0);
    step(5);
    rd(A_CNT, v); check("R2 count 5", v, 32'd5);
    step(24);
    rd(A_STAT, v); check("R3 window shut at 29", v, 32'h00);
    step(1);
    rd(A_STAT, v); check("R3 window open at 30", v, 32'h01);
    stop_timer();
    rd(A_CNT, v); check("R11 count after stop", v, 32'd0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    int r0;
    wr(A_CTRL, 32'h8000);
    step(31);
    wr(A_ARM, 32'h4000);
    wr(A_CONF, 32'h08);
    rd(A_CNT, v);  check("R4 count zeroed", v, 32'd0);
    rd(A_STAT, v); check("R4 status clean", v, 32'h00);
    r0 = req_seen;
    step(35);
    rd(A_CNT, v); check("R4 count resumes", v, 32'd35);
    check("R4 no request", 32'(req_seen - r0), 32'd0);
    stop_timer();
  endtask

  task automatic t_bad_conf();
    logic [31:0] v;
    wr(A_CTRL, 32'h8000);
    wr(A_ARM, 32'h4000);
    wr(A_CONF, 32'h08);
    rd(A_CNT, v);  check("R6 early confirm keeps count", v, 32'd2);
    rd(A_STAT, v); check("R6 early confirm flag", v, 32'h40);
    wr(A_STAT, 32'hE0);
    rd(A_STAT, v); check("R9 flags cleared", v, 32'h00);
    step(28);
    wr(A_CONF, 32'h08);
    rd(A_CNT, v);  check("R6 confirm without arm keeps count", v, 32'd32);
    rd(A_STAT, v); check("R6 confirm without arm flag", v, 32'h41);
    wr(A_STAT, 32'h00);
    rd(A_STAT, v); check("R9 zero write keeps flag", v, 32'h41);
    wr(A_STAT, 32'hE0);
    wr(A_ARM, 32'h4000);
    wr(A_CONF, 32'h55);
    rd(A_CNT, v);  check("R6 wrong confirm key keeps count", v, 32'd36);
    rd(A_STAT, v); check("R6 wrong confirm key flag", v, 32'h41);
    stop_timer();
    wr(A_STAT, 32'hE0);
  endtask

  task automatic t_bad_arm();
    logic [31:0] v;
    wr(A_CTRL, 32'h8000);
    step(30);
    wr(A_ARM, 32'h1200);
    rd(A_STAT, v); check("R5 bad arm flag", v, 32'h81);
    wr(A_CONF, 32'h08);
    rd(A_CNT, v);  check("R5 arm discarded, count kept", v, 32'd32);
    rd(A_STAT, v); check("R5 arm discarded, confirm flagged", v, 32'hC1);
    stop_timer();
    wr(A_STAT, 32'hE0);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    int r0;
    wr(A_PER, 32'd16);
    wr(A_WIN, 32'd4);
    wr(A_CTRL, 32'h8000);
    r0 = req_seen;
    step(15);
    check("R7 no request before expiry", rst_req, 1'b0);
    rd(A_CNT, v); check("R7 count at last", v, 32'd15);
    step(1);
    check("R7 request high", rst_req, 1'b1);
    rd(A_CNT, v);  check("R7 count wrapped", v, 32'd0);
    rd(A_STAT, v); check("R7 event flag", v, 32'h20);
    rd(A_RC, v);   check("R8 cause bit", v, 32'h20);
    check("R8 cause pin", rst_cause, 1'b1);
    step(1);
    check("R7 request dropped", rst_req, 1'b0);
    check("R7 single pulse", 32'(req_seen - r0), 32'd1);
    stop_timer();
    wr(A_STAT, 32'h20);
    rd(A_STAT, v); check("R9 event cleared", v, 32'h00);
    wr(A_RC, 32'h0);
    rd(A_RC, v); check("R8 cause sticky", v, 32'h20);
    wr(A_RC, 32'h20);
    rd(A_RC, v); check("R8 cause cleared", v, 32'h0);
    check("R8 cause pin cleared", rst_cause, 1'b0);
  endtask

  task automatic t_zero_period();
    logic [31:0] v;
    int r0;
    wr(A_PER, 32'd0);
    wr(A_CTRL, 32'h8000);
    r0 = req_seen;
    step(50);
    rd(A_CNT, v);  check("R10 count held", v, 32'd0);
    rd(A_STAT, v); check("R10 no flags", v, 32'h00);
    check("R10 no request", 32'(req_seen - r0), 32'd0);
    stop_timer();
  endtask

  task automatic t_guard();
    logic [31:0] v;
    wr(A_PER, 32'd40);
    wr(A_CTRL, 32'h8000);
    step(3);
    wr(A_CTRL, 32'h0);
    rd(A_PER, v); check("R11 read blocked in quiet slot", v, 32'h0);
    wr(A_PER, 32'd77);
    rd(A_PER, v); check("R11 write dropped in quiet slot", v, 32'd40);
    rd(A_CNT, v); check("R11 count zero after stop", v, 32'd0);
    wr(A_PER, 32'd77);
    rd(A_PER, v); check("R11 write accepted later", v, 32'd77);
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_count();
    t_clear();
    t_bad_conf();
    t_bad_arm();
    t_timeout();
    t_zero_period();
    t_guard();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule